// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a small set of one-bit lock flags that two independent requesters, a left port and a right port, use to share resources without colliding. A port asks for a flag by writing a zero to it. It finds out whether it holds the flag by reading it back: a zero means it holds the flag. It gives the flag up by writing a one. At most one port holds any flag at a time.

A request made while the other side holds the flag is remembered as a waiting request. When the holder gives the flag up, it passes straight to the waiting port. Both ports are sampled on one clock. When both ports act in the same cycle, the left port's action is applied first and the right port's action is applied to the result.

Each port carries a flag-select strobe, a memory enable, a read/write select, an output enable, two byte-lane selects, a flag address and a 16-bit write bus. Read data leaves on a separate 16-bit bus with a per-lane drive indication.

Top module: `semflag_bank`

## Requirements
- R1: After reset every flag is free, so a valid read of any flag from either port returns 16'hFFFF.
- R2: An access counts only when flag_sel_n is 0 and mem_en_n is 1. With both strobes low, or with flag_sel_n high, the flags do not change, rdata is zero and lane_oe is zero.
- R3: A valid read needs is_rd=1, out_en_n=0 and at least one lane_sel_n bit low. It returns the addressed flag's value on all 16 rdata bits and sets lane_oe to the inverse of lane_sel_n. Bit 1 is the lane for bits 15:8 and bit 0 is the lane for bits 7:0. With no valid read, rdata and lane_oe are zero.
- R4: A write (is_rd=0) takes effect only if at least one lane_sel_n bit is low, and it uses only wdata bit 0. Bits 15:1 are ignored.
- R5: The 3-bit addr selects one of eight flags, and an operation on one flag leaves the other flags unchanged.
- R6: A port that writes 0 to a free flag becomes its holder. From the next cycle that port reads 0 and the other port reads 1.
- R7: A port that writes 0 to a flag held by the other port is recorded as waiting. The waiting port keeps reading 1 and the holder keeps reading 0.
- R8: When the holder writes 1, the flag passes to a waiting port if there is one. Otherwise the flag becomes free.
- R9: If both ports write 0 to the same free flag in one cycle, the left port becomes the holder and the right port is recorded as waiting.
- R10: A port that does not hold a flag and writes 1 to it withdraws its waiting request. In the same cycle, the left port's operation is applied before the right port's operation.
- R11: No flag is ever held by both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_flag_sel_n | input | 1 | Left flag-bank select, active low |
| l_mem_en_n | input | 1 | Left memory enable; must be high for a flag access |
| l_is_rd | input | 1 | Left direction: 1 read, 0 write |
| l_out_en_n | input | 1 | Left read output enable, active low |
| l_lane_sel_n | input | 2 | Left byte-lane selects, active low |
| l_addr | input | 3 | Left flag address |
| l_wdata | input | 16 | Left write data; only bit 0 is used |
| l_rdata | output | 16 | Left read data |
| l_lane_oe | output | 2 | Left lanes being driven |
| r_flag_sel_n | input | 1 | Right flag-bank select, active low |
| r_mem_en_n | input | 1 | Right memory enable; must be high for a flag access |
| r_is_rd | input | 1 | Right direction: 1 read, 0 write |
| r_out_en_n | input | 1 | Right read output enable, active low |
| r_lane_sel_n | input | 2 | Right byte-lane selects, active low |
| r_addr | input | 3 | Right flag address |
| r_wdata | input | 16 | Right write data; only bit 0 is used |
| r_rdata | output | 16 | Right read data |
| r_lane_oe | output | 2 | Right lanes being driven |

## Verification
The hardest cases to reach are the same-cycle collisions. One is two zero writes to one free flag. The other is a release by one port in the same cycle as a request from the other. Both need the two ports driven in the same clock with identical addresses and carefully ordered prior ownership. The stimulus first builds the needed holder and waiting state through single-port steps. It then issues the paired operation in one cycle and reads both ports back together. A behavioural model tracks holder and waiting state per flag and is compared on every clock.

// File: rtl/semflag_pkg.sv
package semflag_pkg;

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    typedef struct packed {
        holder_e holder;
        logic    wait_l;
        logic    wait_r;
    } flag_st_t;

    // Apply one port's write (value of data bit 0) to a flag state.
    function automatic flag_st_t step_flag(flag_st_t s, logic from_left, logic val);
        flag_st_t n;
        holder_e  self_h;
        holder_e  peer_h;
        logic     peer_waits;
        n          = s;
        self_h     = from_left ? HOLD_LEFT : HOLD_RIGHT;
        peer_h     = from_left ? HOLD_RIGHT : HOLD_LEFT;
        peer_waits = from_left ? s.wait_r : s.wait_l;
        if (!val) begin
            if (s.holder == HOLD_NONE) begin
                n.holder = self_h;
            end else if (s.holder != self_h) begin
                if (from_left) n.wait_l = 1'b1;
                else           n.wait_r = 1'b1;
            end
        end else begin
            if (s.holder == self_h) begin
                if (peer_waits) begin
                    n.holder = peer_h;
                    if (from_left) n.wait_r = 1'b0;
                    else           n.wait_l = 1'b0;
                end else begin
                    n.holder = HOLD_NONE;
                end
            end else begin
                if (from_left) n.wait_l = 1'b0;
                else           n.wait_r = 1'b0;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/semflag_port_decode.sv
module semflag_port_decode #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              flag_sel_n,
    input  logic              mem_en_n,
    input  logic              is_rd,
    input  logic              out_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_go,
    output logic              wr_val,
    output logic              rd_go,
    output logic [LANES-1:0]  lane_on
);
    logic acc_ok;
    logic any_lane;
    logic unused_hi;

    assign acc_ok    = !flag_sel_n && mem_en_n;
    assign any_lane  = (lane_sel_n != {LANES{1'b1}});
    assign wr_go     = acc_ok && !is_rd && any_lane;
    assign wr_val    = wdata[0];
    assign rd_go     = acc_ok && is_rd && !out_en_n && any_lane;
    assign lane_on   = rd_go ? ~lane_sel_n : '0;
    assign unused_hi = ^wdata[DATA_W-1:1];
endmodule

// File: rtl/semflag_cell.sv
module semflag_cell
    import semflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_wr,
    input  logic l_val,
    input  logic r_wr,
    input  logic r_val,
    output logic held_l,
    output logic held_r
);
    flag_st_t st_d;
    flag_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (l_wr) st_d = step_flag(st_d, 1'b1, l_val);
        if (r_wr) st_d = step_flag(st_d, 1'b0, r_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{holder: HOLD_NONE, wait_l: 1'b0, wait_r: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign held_l = (st_q.holder == HOLD_LEFT);
    assign held_r = (st_q.holder == HOLD_RIGHT);
endmodule

// File: rtl/semflag_read_mux.sv
module semflag_read_mux #(
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic                 rd_go,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_FLAGS-1:0] held,
    output logic [DATA_W-1:0]    rdata
);
    assign rdata = rd_go ? {DATA_W{~held[addr]}} : '0;
endmodule

// File: rtl/semflag_bank.sv
module semflag_bank #(
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS),
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_flag_sel_n,
    input  logic              l_mem_en_n,
    input  logic              l_is_rd,
    input  logic              l_out_en_n,
    input  logic [LANES-1:0]  l_lane_sel_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic [LANES-1:0]  l_lane_oe,
    input  logic              r_flag_sel_n,
    input  logic              r_mem_en_n,
    input  logic              r_is_rd,
    input  logic              r_out_en_n,
    input  logic [LANES-1:0]  r_lane_sel_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic [LANES-1:0]  r_lane_oe
);
    logic l_wr_go, l_wr_val, l_rd_go;
    logic r_wr_go, r_wr_val, r_rd_go;
    logic [NUM_FLAGS-1:0] own_l_vec;
    logic [NUM_FLAGS-1:0] own_r_vec;

    semflag_port_decode #(.DATA_W(DATA_W)) u_dec_l (
        .flag_sel_n (l_flag_sel_n),
        .mem_en_n   (l_mem_en_n),
        .is_rd      (l_is_rd),
        .out_en_n   (l_out_en_n),
        .lane_sel_n (l_lane_sel_n),
        .wdata      (l_wdata),
        .wr_go      (l_wr_go),
        .wr_val     (l_wr_val),
        .rd_go      (l_rd_go),
        .lane_on    (l_lane_oe)
    );

    semflag_port_decode #(.DATA_W(DATA_W)) u_dec_r (
        .flag_sel_n (r_flag_sel_n),
        .mem_en_n   (r_mem_en_n),
        .is_rd      (r_is_rd),
        .out_en_n   (r_out_en_n),
        .lane_sel_n (r_lane_sel_n),
        .wdata      (r_wdata),
        .wr_go      (r_wr_go),
        .wr_val     (r_wr_val),
        .rd_go      (r_rd_go),
        .lane_on    (r_lane_oe)
    );

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        logic l_hit;
        logic r_hit;
        assign l_hit = l_wr_go && (l_addr == ADDR_W'(f));
        assign r_hit = r_wr_go && (r_addr == ADDR_W'(f));
        semflag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_wr   (l_hit),
            .l_val  (l_wr_val),
            .r_wr   (r_hit),
            .r_val  (r_wr_val),
            .held_l (own_l_vec[f]),
            .held_r (own_r_vec[f])
        );
    end

    semflag_read_mux #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_mux_l (
        .rd_go (l_rd_go),
        .addr  (l_addr),
        .held  (own_l_vec),
        .rdata (l_rdata)
    );

    semflag_read_mux #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_mux_r (
        .rd_go (r_rd_go),
        .addr  (r_addr),
        .held  (own_r_vec),
        .rdata (r_rdata)
    );
endmodule

// File: rtl/semflag_bank_chk.sv
module semflag_bank_chk #(
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS),
    localparam int LANES    = DATA_W / 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_flag_sel_n,
    input logic                 l_mem_en_n,
    input logic                 l_is_rd,
    input logic [LANES-1:0]     l_lane_sel_n,
    input logic [ADDR_W-1:0]    l_addr,
    input logic                 l_bit0,
    input logic [DATA_W-1:0]    l_rdata,
    input logic [LANES-1:0]     l_lane_oe,
    input logic                 r_flag_sel_n,
    input logic                 r_mem_en_n,
    input logic                 r_is_rd,
    input logic [LANES-1:0]     r_lane_sel_n,
    input logic [ADDR_W-1:0]    r_addr,
    input logic                 r_bit0,
    input logic [DATA_W-1:0]    r_rdata,
    input logic [LANES-1:0]     r_lane_oe,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r
);
    logic l_req0, r_req0, tie_free;

    assign l_req0 = !l_flag_sel_n && l_mem_en_n && !l_is_rd &&
                    (l_lane_sel_n != '1) && !l_bit0;
    assign r_req0 = !r_flag_sel_n && r_mem_en_n && !r_is_rd &&
                    (r_lane_sel_n != '1) && !r_bit0;
    assign tie_free = l_req0 && r_req0 && (l_addr == r_addr) &&
                      !own_l[l_addr] && !own_r[l_addr];

    // R11
    excl_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    // R2
    conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_flag_sel_n && !l_mem_en_n) |-> (l_lane_oe == '0 && l_rdata == '0));

    // R3
    left_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_lane_oe != '0) |-> (l_rdata == {DATA_W{!own_l[l_addr]}}));

    // R3
    right_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_lane_oe != '0) |-> (r_rdata == {DATA_W{!own_r[r_addr]}}));

    // R9
    tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tie_free |=> own_l[$past(l_addr)]);
endmodule

bind semflag_bank semflag_bank_chk #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .l_flag_sel_n (l_flag_sel_n),
    .l_mem_en_n   (l_mem_en_n),
    .l_is_rd      (l_is_rd),
    .l_lane_sel_n (l_lane_sel_n),
    .l_addr       (l_addr),
    .l_bit0       (l_wdata[0]),
    .l_rdata      (l_rdata),
    .l_lane_oe    (l_lane_oe),
    .r_flag_sel_n (r_flag_sel_n),
    .r_mem_en_n   (r_mem_en_n),
    .r_is_rd      (r_is_rd),
    .r_lane_sel_n (r_lane_sel_n),
    .r_addr       (r_addr),
    .r_bit0       (r_wdata[0]),
    .r_rdata      (r_rdata),
    .r_lane_oe    (r_lane_oe),
    .own_l        (own_l_vec),
    .own_r        (own_r_vec)
);

// File: tb/tb_semflag_bank.sv
module tb_semflag_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        l_flag_sel_n, l_mem_en_n, l_is_rd, l_out_en_n;
    logic [1:0]  l_lane_sel_n;
    logic [2:0]  l_addr;
    logic [15:0] l_wdata, l_rdata;
    logic [1:0]  l_lane_oe;
    logic        r_flag_sel_n, r_mem_en_n, r_is_rd, r_out_en_n;
    logic [1:0]  r_lane_sel_n;
    logic [2:0]  r_addr;
    logic [15:0] r_wdata, r_rdata;
    logic [1:0]  r_lane_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: holder 0 none, 1 left, 2 right
    int holder [8];
    bit wait_l [8];
    bit wait_r [8];

    // stimulus kinds: 0 idle, 1 read, 2 write, 3 write with both strobes low,
    // 4 read with both strobes low, 5 read with output disabled
    int l_kind, r_kind;
    int l_lanes, r_lanes;

    always #4 clk = ~clk;

    semflag_bank dut (.*);

    task automatic set_side(input bit left, input int kind, input int a,
                            input logic [15:0] wd, input int lanes);
        logic sn, cn, rd, oen;
        sn = 1'b0; cn = 1'b1; rd = 1'b1; oen = 1'b1;
        case (kind)
            0: sn = 1'b1;
            1: oen = 1'b0;
            2: rd = 1'b0;
            3: begin cn = 1'b0; rd = 1'b0; end
            4: begin cn = 1'b0; oen = 1'b0; end
            default: ;
        endcase
        if (left) begin
            l_flag_sel_n = sn; l_mem_en_n = cn; l_is_rd = rd; l_out_en_n = oen;
            l_lane_sel_n = ~2'(lanes); l_addr = 3'(a); l_wdata = wd;
            l_kind = kind; l_lanes = lanes;
        end else begin
            r_flag_sel_n = sn; r_mem_en_n = cn; r_is_rd = rd; r_out_en_n = oen;
            r_lane_sel_n = ~2'(lanes); r_addr = 3'(a); r_wdata = wd;
            r_kind = kind; r_lanes = lanes;
        end
    endtask

    task automatic model_apply(input bit left, input int a, input bit v);
        int me, peer;
        me = left ? 1 : 2;
        peer = left ? 2 : 1;
        if (!v) begin
            if (holder[a] == 0) holder[a] = me;
            else if (holder[a] != me) begin
                if (left) wait_l[a] = 1; else wait_r[a] = 1;
            end
        end else if (holder[a] == me) begin
            if (left ? wait_r[a] : wait_l[a]) begin
                holder[a] = peer;
                if (left) wait_r[a] = 0; else wait_l[a] = 0;
            end else holder[a] = 0;
        end else begin
            if (left) wait_l[a] = 0; else wait_r[a] = 0;
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: inputs already set; update model at edge, compare at negedge
    task automatic cyc(input string tag);
        logic [15:0] exp_ld, exp_rd;
        logic [1:0]  exp_lo, exp_ro;
        @(posedge clk);
        if (l_kind == 2 && l_lanes != 0) model_apply(1'b1, int'(l_addr), l_wdata[0]);
        if (r_kind == 2 && r_lanes != 0) model_apply(1'b0, int'(r_addr), r_wdata[0]);
        @(negedge clk);
        exp_ld = 16'h0; exp_lo = 2'b00; exp_rd = 16'h0; exp_ro = 2'b00;
        if (l_kind == 1 && l_lanes != 0) begin
            exp_ld = (holder[l_addr] == 1) ? 16'h0000 : 16'hFFFF;
            exp_lo = 2'(l_lanes);
        end
        if (r_kind == 1 && r_lanes != 0) begin
            exp_rd = (holder[r_addr] == 2) ? 16'h0000 : 16'hFFFF;
            exp_ro = 2'(r_lanes);
        end
        check(tag, "l_rdata", l_rdata, exp_ld);
        check(tag, "l_lane_oe", {14'h0, l_lane_oe}, {14'h0, exp_lo});
        check(tag, "r_rdata", r_rdata, exp_rd);
        check(tag, "r_lane_oe", {14'h0, r_lane_oe}, {14'h0, exp_ro});
    endtask

    task automatic both_read(input int a, input string tag);
        set_side(1'b1, 1, a, 16'h0, 3);
        set_side(1'b0, 1, a, 16'h0, 3);
        cyc(tag);
    endtask

    task automatic one_write(input bit left, input int a, input logic [15:0] wd,
                             input string tag);
        set_side(left, 2, a, wd, 3);
        set_side(!left, 0, 0, 16'h0, 0);
        cyc(tag);
    endtask

    initial begin
        #(8ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin holder[i] = 0; wait_l[i] = 0; wait_r[i] = 0; end
        rst_n = 1'b0;
        set_side(1'b1, 0, 0, 16'h0, 0);
        set_side(1'b0, 0, 0, 16'h0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all flags free after reset
        for (int a = 0; a < 8; a++) both_read(a, "R1");

        // R6 / R4: left takes flag 3 with upper data bits set
        one_write(1'b1, 3, 16'hFFFE, "R4");
        both_read(3, "R6");
        // R3: lane selects
        set_side(1'b1, 1, 3, 16'h0, 1);
        set_side(1'b0, 1, 3, 16'h0, 2);
        cyc("R3");
        set_side(1'b1, 5, 3, 16'h0, 3);
        set_side(1'b0, 1, 3, 16'h0, 0);
        cyc("R3");

        // R7: right waits on flag 3
        one_write(1'b0, 3, 16'h0000, "R7");
        both_read(3, "R7");
        // R8: left releases with only upper lane; right takes over
        set_side(1'b1, 2, 3, 16'h0001, 2);
        set_side(1'b0, 0, 0, 16'h0, 0);
        cyc("R8");
        both_read(3, "R8");
        one_write(1'b0, 3, 16'hFFFF, "R8");
        both_read(3, "R8");

        // R5: independent flags
        one_write(1'b1, 0, 16'h0000, "R5");
        one_write(1'b0, 7, 16'h0000, "R5");
        for (int a = 0; a < 8; a++) both_read(a, "R5");

        // R9: tie on free flag 5
        set_side(1'b1, 2, 5, 16'h0000, 3);
        set_side(1'b0, 2, 5, 16'h0000, 1);
        cyc("R9");
        both_read(5, "R9");
        one_write(1'b1, 5, 16'h0001, "R9");
        both_read(5, "R9");

        // R10: left waits then withdraws; release by right frees the flag
        one_write(1'b1, 5, 16'h0000, "R10");
        one_write(1'b1, 5, 16'h0001, "R10");
        one_write(1'b0, 5, 16'h0001, "R10");
        both_read(5, "R10");
        // R10: same-cycle release (left) and request (right) on flag 0
        set_side(1'b1, 2, 0, 16'h0001, 3);
        set_side(1'b0, 2, 0, 16'h0000, 3);
        cyc("R10");
        both_read(0, "R10");

        // R2: both strobes low is ignored for write and read
        set_side(1'b1, 3, 2, 16'h0000, 3);
        set_side(1'b0, 4, 2, 16'h0000, 3);
        cyc("R2");
        both_read(2, "R2");
        set_side(1'b1, 2, 2, 16'h0000, 0);
        set_side(1'b0, 0, 0, 16'h0, 0);
        cyc("R4");
        one_write(1'b0, 2, 16'h0000, "R2");
        both_read(2, "R2");

        // R11: final sweep
        for (int a = 0; a < 8; a++) both_read(a, "R11");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule